// File: doc/BRIEF.md
# Transport stream output formatter

The formatter sits between a block error-correction decoder and an MPEG transport decoder. The upstream side hands over every decoded byte of a coded block through a valid/ready handshake. That includes the 16 parity bytes that follow each payload. A start-of-block marker comes with the first byte of the block, together with a flag that says whether the block could be corrected. The formatter runs a byte clock at half the system clock rate, and this clock never stops. Each byte takes one period of it. Payload bytes come out with a data-valid flag and a byte strobe. The parity slots still take clock periods, but valid and strobe stay low for them.

Payload length is 188 or 144 bytes, chosen by a configuration input that is read when each block starts. For an uncorrectable block, the formatter sets the error indicator bit inside the packet header. It also raises a separate error output that lasts for the whole block. A second configuration input chooses the byte-clock edge on which the outputs change. This lets the downstream part sample on the opposite edge, either rising or falling.

Top module: `ts_out_formatter`

## Requirements
- R1: A synchronous reset clears the block position and drives outValid, outSync, outStrobe, outErr and outData to 0. After reset no byte is output until a byte arrives with inSop high.
- R2: outClk inverts on every system clock edge, so one byte slot is two system clock cycles. It keeps toggling through parity slots, through idle slots and while no block is open.
- R3: With cfgSampleFall=0, outputs change only at the edge where outClk falls. With cfgSampleFall=1, they change only where outClk rises. inReady is high only in the system cycle just before such a launch edge, and a byte is taken at that edge when inValid is high.
- R4: cfgShort=0 gives a 188-byte payload and cfgShort=1 gives a 144-byte payload. Each block is the payload plus 16 parity bytes. The length is latched on the block's first byte, so changing cfgShort mid-block has no effect on that block.
- R5: outValid is 1 for payload bytes and 0 for the 16 parity slots. outData is 0 during parity slots.
- R6: outSync is 1 only during the slot that carries the block's first payload byte.
- R7: outStrobe is 0 at each launch edge. It goes high half a slot later if outValid is high, so it rises once per payload byte and stays low through parity slots.
- R8: In the byte at payload index 1, bit 7 (the transport error indicator) is forced to 1 when the block's inUncorr flag was set. Otherwise that byte passes through unchanged.
- R9: outErr takes the block's inUncorr value at the block's first byte and holds it until the first byte of the next block, including through idle and discarded slots.
- R10: A slot with no byte offered, or with a byte offered without inSop while no block is open, outputs outValid=0, outSync=0 and outStrobe=0.
- R11: A byte with inSop high always starts a new block at index 0, even in the middle of a block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| cfgShort | input | 1 | 1 selects 144-byte payload, 0 selects 188 |
| cfgSampleFall | input | 1 | 1: downstream samples on falling outClk edge (outputs launch on rising) |
| inData | input | 8 | Decoded byte from upstream |
| inValid | input | 1 | inData holds a byte |
| inSop | input | 1 | Byte is the first of a coded block |
| inUncorr | input | 1 | Block could not be corrected (read with inSop) |
| inReady | output | 1 | Byte will be taken at the next clock edge |
| outClk | output | 1 | Free-running byte clock |
| outData | output | 8 | Output byte |
| outValid | output | 1 | outData is a payload byte |
| outSync | output | 1 | First payload byte of a block |
| outStrobe | output | 1 | Rises mid-slot for each payload byte |
| outErr | output | 1 | Current block is uncorrectable |

## Verification
A byte offered while inReady is high is taken at the next system clock edge, and that same edge is the launch edge. So outData, outValid, outSync and outErr show that byte one system cycle after it is offered. outStrobe follows one system cycle later, at the mid-slot edge. The bench drives inputs and samples outputs on the falling system clock edge. It reads the launched values at the first falling edge after the accept and the strobe and mid-slot clock level at the second. Each call handles exactly one slot, so the position inside a block is known from the call count alone.

// File: rtl/ts_fmt_pkg.sv
package ts_fmt_pkg;

  // Per-edge control strobes from control to datapath
  typedef struct packed {
    logic launch;    // the coming edge is a launch edge
    logic take;      // a byte belonging to a block is taken at that edge
    logic first;     // it is the first byte of a block
    logic parity;    // it sits in a parity slot
    logic teiForce;  // force the error indicator bit in this byte
    logic errNew;    // error status for the block starting now
  } fmtStrb_t;

endpackage

// File: rtl/ts_fmt_ctrl.sv
module ts_fmt_ctrl
  import ts_fmt_pkg::*;
#(
  parameter int LONG_LEN   = 188,
  parameter int SHORT_LEN  = 144,
  parameter int PARITY_LEN = 16,
  parameter int TEI_IDX    = 1
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     cfgShort,
  input  logic     cfgSampleFall,
  input  logic     inValid,
  input  logic     inSop,
  input  logic     inUncorr,
  output logic     inReady,
  output logic     outClk,
  output fmtStrb_t strb
);

  localparam int IDX_W = $clog2(LONG_LEN + PARITY_LEN + 1);
  localparam logic [IDX_W-1:0] LONG_V   = IDX_W'(LONG_LEN);
  localparam logic [IDX_W-1:0] SHORT_V  = IDX_W'(SHORT_LEN);
  localparam logic [IDX_W-1:0] PAR_V    = IDX_W'(PARITY_LEN);
  localparam logic [IDX_W-1:0] TEI_V    = IDX_W'(TEI_IDX);

  logic             phase;
  logic             inBlock;
  logic [IDX_W-1:0] idx;
  logic [IDX_W-1:0] curLen;
  logic             blkErr;
  logic             slotOpen;
  logic             accept;
  logic             lastByte;

  assign slotOpen = (phase != cfgSampleFall);
  assign inReady  = slotOpen && !rst;
  assign accept   = inReady && inValid;
  assign lastByte = (idx == curLen + PAR_V - 1'b1);
  assign outClk   = phase;

  always_comb begin
    strb.launch   = slotOpen;
    strb.take     = accept && (inSop || inBlock);
    strb.first    = inSop;
    strb.parity   = !inSop && (idx >= curLen);
    strb.teiForce = !inSop && (idx == TEI_V) && blkErr;
    strb.errNew   = inUncorr;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase   <= 1'b0;
      inBlock <= 1'b0;
      idx     <= '0;
      curLen  <= LONG_V;
      blkErr  <= 1'b0;
    end else begin
      phase <= !phase;
      if (accept) begin
        if (inSop) begin
          inBlock <= 1'b1;
          idx     <= IDX_W'(1);
          curLen  <= cfgShort ? SHORT_V : LONG_V;
          blkErr  <= inUncorr;
        end else if (inBlock) begin
          if (lastByte) begin
            inBlock <= 1'b0;
            idx     <= '0;
          end else begin
            idx <= idx + 1'b1;
          end
        end
      end
    end
  end

  // R2
  clk_toggle_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> outClk != $past(outClk));

  // R3
  ready_gap_chk: assert property (@(posedge clk) disable iff (rst)
    inReady |=> !inReady);

  // R11
  restart_chk: assert property (@(posedge clk) disable iff (rst)
    accept && inSop |=> inBlock && idx == IDX_W'(1));

endmodule

// File: rtl/ts_fmt_dpath.sv
module ts_fmt_dpath
  import ts_fmt_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int TEI_BIT = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  fmtStrb_t          strb,
  input  logic [DATA_W-1:0] inData,
  output logic [DATA_W-1:0] outData,
  output logic              outValid,
  output logic              outSync,
  output logic              outStrobe,
  output logic              outErr
);

  localparam logic [DATA_W-1:0] TEI_MASK = DATA_W'(1) << TEI_BIT;

  logic [DATA_W-1:0] nextByte;

  always_comb begin
    if (strb.parity)        nextByte = '0;
    else if (strb.teiForce) nextByte = inData | TEI_MASK;
    else                    nextByte = inData;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      outData   <= '0;
      outValid  <= 1'b0;
      outSync   <= 1'b0;
      outStrobe <= 1'b0;
      outErr    <= 1'b0;
    end else if (strb.launch) begin
      outStrobe <= 1'b0;
      if (strb.take) begin
        outData  <= nextByte;
        outValid <= !strb.parity;
        outSync  <= strb.first;
        if (strb.first) outErr <= strb.errNew;
      end else begin
        outValid <= 1'b0;
        outSync  <= 1'b0;
      end
    end else begin
      outStrobe <= outValid;
    end
  end

  // R6
  sync_valid_chk: assert property (@(posedge clk) disable iff (rst)
    outSync |-> outValid);

  // R7
  strobe_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(outStrobe) |-> outValid);

  // R3
  launch_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !strb.launch |=> $stable(outData) && $stable(outValid) && $stable(outSync));

  // R5
  parity_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    strb.launch && strb.take && strb.parity |=> !outValid && !outStrobe);

  // R9
  err_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(outErr) |-> outSync);

endmodule

// File: rtl/ts_out_formatter.sv
module ts_out_formatter
  import ts_fmt_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int LONG_LEN   = 188,
  parameter int SHORT_LEN  = 144,
  parameter int PARITY_LEN = 16,
  parameter int TEI_IDX    = 1,
  parameter int TEI_BIT    = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfgShort,
  input  logic              cfgSampleFall,
  input  logic [DATA_W-1:0] inData,
  input  logic              inValid,
  input  logic              inSop,
  input  logic              inUncorr,
  output logic              inReady,
  output logic              outClk,
  output logic [DATA_W-1:0] outData,
  output logic              outValid,
  output logic              outSync,
  output logic              outStrobe,
  output logic              outErr
);

  fmtStrb_t strb;

  ts_fmt_ctrl #(
    .LONG_LEN   (LONG_LEN),
    .SHORT_LEN  (SHORT_LEN),
    .PARITY_LEN (PARITY_LEN),
    .TEI_IDX    (TEI_IDX)
  ) uCtrl (
    .clk           (clk),
    .rst           (rst),
    .cfgShort      (cfgShort),
    .cfgSampleFall (cfgSampleFall),
    .inValid       (inValid),
    .inSop         (inSop),
    .inUncorr      (inUncorr),
    .inReady       (inReady),
    .outClk        (outClk),
    .strb          (strb)
  );

  ts_fmt_dpath #(
    .DATA_W  (DATA_W),
    .TEI_BIT (TEI_BIT)
  ) uDpath (
    .clk       (clk),
    .rst       (rst),
    .strb      (strb),
    .inData    (inData),
    .outData   (outData),
    .outValid  (outValid),
    .outSync   (outSync),
    .outStrobe (outStrobe),
    .outErr    (outErr)
  );

endmodule

// File: tb/sim_ts_out_formatter.sv
module sim_ts_out_formatter;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cfgShort = 1'b0;
  logic       cfgSampleFall = 1'b0;
  logic [7:0] inData = '0;
  logic       inValid = 1'b0;
  logic       inSop = 1'b0;
  logic       inUncorr = 1'b0;
  logic       inReady, outClk, outValid, outSync, outStrobe, outErr;
  logic [7:0] outData;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  ts_out_formatter u0 (
    .clk(clk), .rst(rst), .cfgShort(cfgShort), .cfgSampleFall(cfgSampleFall),
    .inData(inData), .inValid(inValid), .inSop(inSop), .inUncorr(inUncorr),
    .inReady(inReady), .outClk(outClk), .outData(outData), .outValid(outValid),
    .outSync(outSync), .outStrobe(outStrobe), .outErr(outErr)
  );

  // {cfgSampleFall, cfgShort, uncorrectable, byte at index 1}
  localparam logic [10:0] VEC [4] = '{
    {1'b0, 1'b0, 1'b0, 8'h05},
    {1'b0, 1'b1, 1'b1, 8'h1F},
    {1'b1, 1'b0, 1'b1, 8'h40},
    {1'b1, 1'b1, 1'b0, 8'h9F}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // One slot: offer a byte, return launched outputs and the mid-slot values
  task automatic sendByte(input logic [7:0] d, input logic sop, input logic unc,
                          output logic v, output logic s, output logic [7:0] dat,
                          output logic e, output logic stb, output logic ckL,
                          output logic ckM);
    while (!inReady) @(negedge clk);
    inData = d; inValid = 1'b1; inSop = sop; inUncorr = unc;
    @(negedge clk);
    inValid = 1'b0; inSop = 1'b0; inUncorr = 1'b0;
    v = outValid; s = outSync; dat = outData; e = outErr; ckL = outClk;
    @(negedge clk);
    stb = outStrobe; ckM = outClk;
  endtask

  task automatic sendBlock(input logic shortSel, input logic unc,
                           input logic [7:0] b1, input logic flip);
    int len;
    int nValid;
    logic v, s, e, stb, ckL, ckM;
    logic [7:0] dat, d, expD;
    len = shortSel ? 144 : 188;
    nValid = 0;
    cfgShort = shortSel;
    for (int i = 0; i < len + 16; i++) begin
      if (flip && i == 5) cfgShort = !shortSel;
      if (i == 0)        d = 8'h47;
      else if (i == 1)   d = b1;
      else if (i < len)  d = 8'(i * 13 + 7);
      else               d = 8'hC3 ^ 8'(i);
      expD = (i >= len) ? 8'h00 : ((i == 1 && unc) ? (d | 8'h80) : d);
      sendByte(d, i == 0, unc, v, s, dat, e, stb, ckL, ckM);
      chk("R5 valid", v, i < len);
      chk("R6 sync", s, i == 0);
      if (i == 1) chk("R8 tei byte", dat, expD);
      else        chk("R5 data", dat, expD);
      chk("R9 error", e, unc);
      chk("R7 strobe", stb, i < len);
      chk("R3 launch clk level", ckL, cfgSampleFall);
      chk("R2 mid clk level", ckM, !cfgSampleFall);
      if (v) nValid++;
    end
    chk("R4 payload count", nValid, len);
  endtask

  initial begin
    #1ms;
    fails++;
    $display("FAIL R3 watchdog actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic v, s, e, stb, ckL, ckM, prev;
    logic [7:0] dat;

    repeat (4) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    chk("R1 reset valid", outValid, 0);
    chk("R1 reset sync", outSync, 0);
    chk("R1 reset strobe", outStrobe, 0);
    chk("R1 reset err", outErr, 0);
    chk("R1 reset data", outData, 0);
    rst = 1'b0;

    // R1: no output before a start marker
    sendByte(8'h11, 1'b0, 1'b0, v, s, dat, e, stb, ckL, ckM);
    chk("R1 no marker valid", v, 0);

    // Table of blocks across both lengths, both launch edges, both error states
    for (int n = 0; n < 4; n++) begin
      cfgSampleFall = VEC[n][10];
      @(negedge clk);
      sendBlock(VEC[n][9], VEC[n][8], VEC[n][7:0], 1'b0);
    end

    // R9 hold through discarded bytes; R10 discard without marker
    sendBlock(1'b1, 1'b1, 8'h22, 1'b0);
    for (int k = 0; k < 3; k++) begin
      sendByte(8'h33, 1'b0, 1'b0, v, s, dat, e, stb, ckL, ckM);
      chk("R10 discard valid", v, 0);
      chk("R10 discard sync", s, 0);
      chk("R10 discard strobe", stb, 0);
      chk("R9 error held", e, 1);
    end

    // R2 clock runs while idle; R10 idle outputs
    for (int k = 0; k < 6; k++) begin
      prev = outClk;
      @(negedge clk);
      chk("R2 idle toggle", outClk, !prev);
      chk("R10 idle valid", outValid, 0);
    end

    // R11 restart mid-block; R9 clears at next first byte
    cfgShort = 1'b0;
    for (int i = 0; i < 10; i++) begin
      sendByte(i == 0 ? 8'h47 : 8'(i + 100), i == 0, 1'b0, v, s, dat, e, stb, ckL, ckM);
      if (i == 0) chk("R9 error cleared", e, 0);
      chk("R11 partial valid", v, 1);
    end
    sendBlock(1'b1, 1'b0, 8'h01, 1'b0);

    // R4 length latched at block start
    sendBlock(1'b0, 1'b0, 8'h02, 1'b1);
    sendBlock(1'b1, 1'b1, 8'h03, 1'b1);

    // R1 reset mid-block, then marker required again
    for (int i = 0; i < 4; i++)
      sendByte(8'(i + 1), i == 0, 1'b1, v, s, dat, e, stb, ckL, ckM);
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk("R1 mid reset valid", outValid, 0);
    chk("R1 mid reset err", outErr, 0);
    chk("R1 mid reset strobe", outStrobe, 0);
    chk("R1 mid reset data", outData, 0);
    rst = 1'b0;
    sendByte(8'h55, 1'b0, 1'b0, v, s, dat, e, stb, ckL, ckM);
    chk("R1 after reset discard", v, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule